// File: doc/BRIEF.md
# Indirect Host Port with Microcode Loader

This block gives an external host an 8-bit bus with a 2-bit address. Through that bus the host can do four things. It can reach a small file of indirect registers. It can drain a FIFO of sliced data that an internal producer fills. It can service a sticky status register whose bits are cleared by writing 1. It can also download microcode into an internal program RAM that the embedded processor fetches from.

Indirect writes are not instantaneous. Each accepted data write occupies the internal bus for a fixed number of cycles. When that time is up, a cycle-complete status bit is set, so the host can poll for it or take it as an interrupt before issuing the next byte.

For a download, the host selects the microcode register and then streams bytes. Each byte lands at an auto-incrementing RAM pointer. During this time the processor's program counter is held at zero. A write of any value to the release register lets the processor run.

Top module: `host_ucode_port`

## Requirements
- R1: Host address 0 reads and writes the indirect index. Host address 1 reads and writes the indirect register that the index selects. Indices 0x00 to 0x0F form a plain register file that resets to zero.
- R2: A host read at address 2 returns the oldest byte in the slice FIFO and removes it, so bytes come out in the order they were pushed.
- R3: A host read at address 2 while the FIFO is empty returns 0x00 and sets status bit 2 (underflow).
- R4: Host address 3 reads the status as {5'b0, underflow, overrun, cycle-complete}. Each bit stays set once its event occurs. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged.
- R5: An accepted data write clears status bit 0 (cycle-complete). Bit 0 reads 1 again on the fourth clock edge after the edge that accepted the write, and not before.
- R6: A data write that arrives while an internal write is still in progress sets status bit 1 (overrun) and has no other effect.
- R7: Writing index 0x7E resets the microcode pointer to zero. Each accepted data write while index 0x7E is selected stores the byte at the pointer and advances the pointer. The stored bytes are readable on the processor fetch port.
- R8: The processor hold output is 1 from reset and stays 1 through microcode writes. It drops to 0 after an accepted data write to index 0x7F, whatever the data value.
- R9: Index 0xC1 is the interrupt-enable register, with its bits in the same positions as the status bits. The interrupt output is high exactly when some status bit and its enable bit are both 1.
- R10: After reset, the status register reads 0x00, the interrupt output is low and the hold output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Host access strobe, one access per asserted cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the access cycle |
| host_irq | output | 1 | Host interrupt |
| slice_push | input | 1 | Producer push into the slice FIFO |
| slice_data | input | 8 | Producer data |
| cpu_hold | output | 1 | Holds the processor program counter at zero |
| cpu_fetch_addr | input | $clog2(UC_DEPTH) | Processor fetch address into program RAM |
| cpu_fetch_data | output | 8 | Program RAM byte at the fetch address |

## Verification
The bench builds the block with its default parameters: 16 plain registers, an 8-entry FIFO, a 64-byte program RAM and a 4-cycle internal write. The short write time makes it practical to read the cycle-complete bit on every edge of a write, and to land a second write inside the busy window to provoke an overrun. The small FIFO is pushed and then drained past empty, which reaches the underflow path. The 64-byte RAM shows that the pointer restarts at zero when the microcode index is reselected.

// File: rtl/host_ucode_port.sv
module host_ucode_port #(
  parameter int REGS       = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int UC_DEPTH   = 64,
  parameter int WR_CYCLES  = 4,
  parameter logic [7:0] UC_IDX  = 8'h7E,
  parameter logic [7:0] REL_IDX = 8'h7F,
  parameter logic [7:0] IEN_IDX = 8'hC1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_cs,
  input  logic                        host_we,
  input  logic [1:0]                  host_addr,
  input  logic [7:0]                  host_wdata,
  output logic [7:0]                  host_rdata,
  output logic                        host_irq,
  input  logic                        slice_push,
  input  logic [7:0]                  slice_data,
  output logic                        cpu_hold,
  input  logic [$clog2(UC_DEPTH)-1:0] cpu_fetch_addr,
  output logic [7:0]                  cpu_fetch_data
);
  localparam int RAW = $clog2(REGS);
  localparam int FAW = $clog2(FIFO_DEPTH);
  localparam int UAW = $clog2(UC_DEPTH);
  localparam int CW  = $clog2(WR_CYCLES + 1);
  localparam logic [7:0] REGS8 = 8'(REGS);

  logic [7:0]     idx;
  logic [7:0]     ien;
  logic [2:0]     stat;
  logic [CW-1:0]  cnt;
  logic [UAW-1:0] ptr;
  logic [7:0]     regs   [REGS];
  logic [7:0]     uc_ram [UC_DEPTH];
  logic [7:0]     fmem   [FIFO_DEPTH];
  logic [FAW-1:0] rp, wp;
  logic [FAW:0]   fcnt;

  wire wr     = host_cs & host_we;
  wire rd     = host_cs & ~host_we;
  wire wr_idx = wr && host_addr == 2'd0;
  wire wr_dat = wr && host_addr == 2'd1;
  wire wr_st  = wr && host_addr == 2'd3;
  wire busy   = cnt != '0;
  wire dat_go = wr_dat & ~busy;
  wire empty  = fcnt == '0;
  wire full   = fcnt == (FAW+1)'(FIFO_DEPTH);
  wire pop_rq = rd && host_addr == 2'd2;
  wire pop    = pop_rq & ~empty;
  wire push   = slice_push & ~full;
  wire in_rf  = idx < REGS8;

  assign host_irq       = |(stat & ien[2:0]);
  assign cpu_fetch_data = uc_ram[cpu_fetch_addr];

  always_comb begin
    host_rdata = 8'h00;
    case (host_addr)
      2'd0: host_rdata = idx;
      2'd1: if (idx == IEN_IDX) host_rdata = ien;
            else if (in_rf)     host_rdata = regs[idx[RAW-1:0]];
      2'd2: if (!empty)         host_rdata = fmem[rp];
      default: host_rdata = {5'b0, stat};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      ien      <= '0;
      stat     <= '0;
      cnt      <= '0;
      ptr      <= '0;
      cpu_hold <= 1'b1;
      for (int i = 0; i < REGS; i++) regs[i] <= '0;
    end else begin
      if (wr_idx) begin
        idx <= host_wdata;
        if (host_wdata == UC_IDX) ptr <= '0;
      end
      if (dat_go) begin
        cnt <= CW'(WR_CYCLES);
        if (idx == IEN_IDX) ien <= host_wdata;
        if (in_rf) regs[idx[RAW-1:0]] <= host_wdata;
        if (idx == UC_IDX) begin
          ptr      <= ptr + UAW'(1);
          cpu_hold <= 1'b1;
        end
        if (idx == REL_IDX) cpu_hold <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - CW'(1);
      end

      if (dat_go)                          stat[0] <= 1'b0;
      else if (cnt == CW'(1))              stat[0] <= 1'b1;
      else if (wr_st && host_wdata[0])     stat[0] <= 1'b0;

      if (wr_dat && busy)                  stat[1] <= 1'b1;
      else if (wr_st && host_wdata[1])     stat[1] <= 1'b0;

      if (pop_rq && empty)                 stat[2] <= 1'b1;
      else if (wr_st && host_wdata[2])     stat[2] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_go && idx == UC_IDX) uc_ram[ptr] <= host_wdata;
    if (push) fmem[wp] <= slice_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp   <= '0;
      wp   <= '0;
      fcnt <= '0;
    end else begin
      if (push) wp <= (wp == FAW'(FIFO_DEPTH-1)) ? '0 : wp + FAW'(1);
      if (pop)  rp <= (rp == FAW'(FIFO_DEPTH-1)) ? '0 : rp + FAW'(1);
      if (push && !pop)      fcnt <= fcnt + (FAW+1)'(1);
      else if (pop && !push) fcnt <= fcnt - (FAW+1)'(1);
    end
  end
endmodule

// File: rtl/host_ucode_port_chk.sv
module host_ucode_port_chk #(
  parameter int UAW = 6,
  parameter logic [7:0] UC_IDX  = 8'h7E,
  parameter logic [7:0] REL_IDX = 8'h7F
) (
  input logic           clk,
  input logic           rst_n,
  input logic           host_cs,
  input logic           host_we,
  input logic [1:0]     host_addr,
  input logic           host_irq,
  input logic           cpu_hold,
  input logic [7:0]     idx,
  input logic [2:0]     stat,
  input logic           busy,
  input logic           empty,
  input logic [UAW-1:0] ptr
);
  wire dwr = host_cs && host_we && host_addr == 2'd1;

  p_cc_low_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !stat[0]);

  p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && busy) |=> stat[1]);

  p_underflow_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && !host_we && host_addr == 2'd2 && empty) |=> stat[2]);

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && !busy && idx == UC_IDX) |=> ptr == $past(ptr) + UAW'(1));

  p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> $past(dwr && idx == REL_IDX));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> stat != 3'b000);
endmodule

bind host_ucode_port host_ucode_port_chk #(
  .UAW($clog2(UC_DEPTH)), .UC_IDX(UC_IDX), .REL_IDX(REL_IDX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
  .host_addr(host_addr), .host_irq(host_irq), .cpu_hold(cpu_hold),
  .idx(idx), .stat(stat), .busy(busy), .empty(empty), .ptr(ptr)
);

// File: tb/host_ucode_port_tb_top.sv
`timescale 1ns/1ps
module host_ucode_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs = 1'b0, host_we = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_irq;
  logic       slice_push = 1'b0;
  logic [7:0] slice_data = '0;
  logic       cpu_hold;
  logic [5:0] cpu_fetch_addr = '0;
  logic [7:0] cpu_fetch_data;
  int checks = 0, errors = 0;
  logic [7:0] q;

  always #2.5 clk = ~clk;

  host_ucode_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .slice_push(slice_push), .slice_data(slice_data),
    .cpu_hold(cpu_hold), .cpu_fetch_addr(cpu_fetch_addr),
    .cpu_fetch_data(cpu_fetch_data)
  );

  // {we, addr, wdata, check, expected}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h03, 1'b0, 8'h00},
    {1'b1, 2'd1, 8'hA5, 1'b0, 8'h00},
    {1'b1, 2'd0, 8'h07, 1'b0, 8'h00},
    {1'b1, 2'd1, 8'h3C, 1'b0, 8'h00},
    {1'b1, 2'd0, 8'h03, 1'b0, 8'h00},
    {1'b0, 2'd1, 8'h00, 1'b1, 8'hA5},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'h03},
    {1'b1, 2'd0, 8'h07, 1'b0, 8'h00},
    {1'b0, 2'd1, 8'h00, 1'b1, 8'h3C},
    {1'b0, 2'd3, 8'h00, 1'b1, 8'h01},
    {1'b1, 2'd3, 8'h01, 1'b0, 8'h00},
    {1'b0, 2'd3, 8'h00, 1'b1, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [1:0] a, input logic [7:0] d,
                     output logic [7:0] r);
    @(negedge clk);
    host_cs = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    #1 r = host_rdata;
    @(posedge clk);
    #1 host_cs = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    acc(1'b1, a, d, dummy);
    idle(5);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    slice_push = 1'b1; slice_data = d;
    @(posedge clk);
    #1 slice_push = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R10 hold", {7'b0, cpu_hold}, 8'h01);
    check("R10 irq", {7'b0, host_irq}, 8'h00);
    acc(1'b0, 2'd3, 8'h00, q); check("R10 status", q, 8'h00);

    // R1 and R4 via vector table
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][19], VEC[i][18:17], VEC[i][16:9], q);
      if (VEC[i][8]) check($sformatf("R1/R4 vector %0d", i), q, VEC[i][7:0]);
      idle(5);
    end

    // R5 cycle-complete timing
    acc(1'b1, 2'd0, 8'h02, q); idle(5);
    acc(1'b1, 2'd1, 8'h66, q);
    for (int k = 1; k <= 5; k++) begin
      acc(1'b0, 2'd3, 8'h00, q);
      check($sformatf("R5 cc edge %0d", k), q, (k == 5) ? 8'h01 : 8'h00);
    end

    // R6 overrun, second write ignored
    acc(1'b1, 2'd1, 8'h22, q);
    acc(1'b1, 2'd1, 8'h33, q);
    idle(6);
    acc(1'b0, 2'd1, 8'h00, q); check("R6 write ignored", q, 8'h22);
    acc(1'b0, 2'd3, 8'h00, q); check("R6 overrun bit", q, 8'h03);

    // R4 write-one-to-clear
    acc(1'b1, 2'd3, 8'h02, q);
    acc(1'b0, 2'd3, 8'h00, q); check("R4 clear bit1 only", q, 8'h01);
    acc(1'b1, 2'd3, 8'h00, q);
    acc(1'b0, 2'd3, 8'h00, q); check("R4 zero no effect", q, 8'h01);
    acc(1'b1, 2'd3, 8'h01, q);
    acc(1'b0, 2'd3, 8'h00, q); check("R4 clear bit0", q, 8'h00);

    // R3 underflow
    acc(1'b0, 2'd2, 8'h00, q); check("R3 empty data", q, 8'h00);
    acc(1'b0, 2'd3, 8'h00, q); check("R3 underflow bit", q, 8'h04);
    acc(1'b1, 2'd3, 8'h04, q);

    // R2 FIFO order
    push(8'h10); push(8'h20); push(8'h30);
    acc(1'b0, 2'd2, 8'h00, q); check("R2 pop 1", q, 8'h10);
    acc(1'b0, 2'd2, 8'h00, q); check("R2 pop 2", q, 8'h20);
    acc(1'b0, 2'd2, 8'h00, q); check("R2 pop 3", q, 8'h30);
    acc(1'b0, 2'd2, 8'h00, q); check("R2 drained", q, 8'h00);
    acc(1'b1, 2'd3, 8'h07, q);

    // R7 microcode download, R8 hold
    wr(2'd0, 8'h7E);
    wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33);
    @(negedge clk); #1;
    check("R8 hold during load", {7'b0, cpu_hold}, 8'h01);
    cpu_fetch_addr = 6'd0; #1 check("R7 ram 0", cpu_fetch_data, 8'h11);
    cpu_fetch_addr = 6'd1; #1 check("R7 ram 1", cpu_fetch_data, 8'h22);
    cpu_fetch_addr = 6'd2; #1 check("R7 ram 2", cpu_fetch_data, 8'h33);
    wr(2'd0, 8'h7E);
    wr(2'd1, 8'h44);
    @(negedge clk); cpu_fetch_addr = 6'd0; #1 check("R7 pointer restart", cpu_fetch_data, 8'h44);
    cpu_fetch_addr = 6'd1; #1 check("R7 next kept", cpu_fetch_data, 8'h22);
    wr(2'd0, 8'h7F);
    @(negedge clk); #1 check("R8 still held", {7'b0, cpu_hold}, 8'h01);
    wr(2'd1, 8'h5A);
    @(negedge clk); #1 check("R8 released", {7'b0, cpu_hold}, 8'h00);

    // R9 interrupt enable
    @(negedge clk); #1 check("R9 irq off no enable", {7'b0, host_irq}, 8'h00);
    wr(2'd0, 8'hC1);
    wr(2'd1, 8'h01);
    @(negedge clk); #1 check("R9 irq on", {7'b0, host_irq}, 8'h01);
    acc(1'b0, 2'd1, 8'h00, q); check("R9 enable readback", q, 8'h01);
    acc(1'b1, 2'd3, 8'h01, q);
    @(negedge clk); #1 check("R9 irq cleared", {7'b0, host_irq}, 8'h00);
    wr(2'd1, 8'h00);
    @(negedge clk); #1 check("R9 irq masked", {7'b0, host_irq}, 8'h00);
    acc(1'b0, 2'd3, 8'h00, q); check("R9 status still set", q, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule